// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Controller

This block is the digital control part of a frequency synthesizer loop. Two one-cycle enable inputs stand for edges of the two loop clocks. `ref_en` stands for the reference clock. A fixed divider turns it into a comparison tick, one per 18 reference edges. `vco_en` stands for the oscillator. A dual-modulus prescaler counts its edges, followed by a swallow counter and a main counter. Together they close one feedback period every N = 4·No − A oscillator edges. During the first A prescaler periods of each feedback period, the prescaler divides by 3. For the rest of the period it divides by 4.

A phase-frequency detector compares the comparison tick with the feedback tick and produces up and down requests. A lock monitor checks each comparison. It raises an active-low unlock flag to high once the loop has been aligned long enough, and drops the flag again on the first misaligned comparison.

The No and A ratio values are shifted in over a three-wire serial port. The lines are serial data, a shift clock and a latch strobe. A latched word takes effect only at the next feedback period boundary. A word with No not greater than A is dropped.

Top module: `pss_synth_ctrl`

## Requirements
- R1: `ref_tick` pulses for one cycle once per 18 cycles with `ref_en` high, counted from reset.
- R2: The feedback period, counted in cycles with `vco_en` high, equals 4·No − A. `fb_tick` pulses the cycle after the enable that completes it. After reset No=5 and A=2, which gives 18.
- R3: `mod_ctl` is high for the first A prescaler periods of each feedback period. While it is high the prescaler divides by 3, so exactly 3·A oscillator edges are counted with `mod_ctl` high in each period.
- R4: Serial bits are taken MSB first on each rising `ser_clk`. The 20-bit word carries No in bits 19..8 and A in bits 7..0. Shifting without a rising `ser_le` leaves the active ratio unchanged. A rising `ser_le` by itself latches the word already shifted in.
- R5: A latched word with No ≤ A is ignored, and the previous ratio stays in force.
- R6: An accepted ratio takes effect only at a feedback period boundary. The period in progress when the strobe rises completes with the old N.
- R7: `up` sets on a comparison tick and `dn` sets on a feedback tick. Once both are high they clear on the next cycle. Ticks in the same cycle raise both together.
- R8: `unlock_n` goes high after 16 consecutive comparisons whose two ticks are at most 2 cycles apart. With a constant offset of 3 cycles it stays low.
- R9: A comparison whose ticks are more than 2 cycles apart drives `unlock_n` low on the next cycle.
- R10: While `rst` is high, `unlock_n`, `up` and `dn` are low, every counter is cleared and the ratio returns to No=5, A=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | One pulse per reference edge |
| vco_en | input | 1 | One pulse per oscillator edge |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; its rising edge applies the word |
| ref_tick | output | 1 | Comparison tick from the fixed divider |
| fb_tick | output | 1 | Feedback period tick |
| mod_ctl | output | 1 | High while the prescaler divides by 3 |
| up | output | 1 | Phase detector up request |
| dn | output | 1 | Phase detector down request |
| unlock_n | output | 1 | Low when not locked |

## Verification
The hardest state to reach from the ports is a controlled phase relation between the two ticks, because the lock window is only 2 cycles wide and the two dividers run freely. The bench resets the block, drives both enables every cycle and holds `vco_en` back for a chosen number of cycles after reset. This places the feedback tick exactly 0, 2 or 3 cycles behind the comparison tick. A second hard case is a ratio strobe that lands mid-period. The bench records the interval of every feedback period in a ring, so it can check the period that straddles the strobe separately from the periods after it.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int NO_W   = 12;
  localparam int A_W    = 8;
  localparam int WORD_W = NO_W + A_W;
  localparam int PRE_HI = 4;
  localparam int PRE_LO = 3;
  localparam int PW     = $clog2(PRE_HI);
  localparam int TD_W   = NO_W + PW;

  typedef struct packed {
    logic [NO_W-1:0] no;
    logic [A_W-1:0]  a;
  } ratio_t;

  // a ratio is usable only when the main count exceeds the swallow count
  function automatic logic ratio_ok(input ratio_t r);
    return 32'(r.no) > 32'(r.a);
  endfunction

  // oscillator edges per feedback period: PRE_HI*(No-A) + PRE_LO*A
  function automatic logic [TD_W-1:0] total_div(input ratio_t r);
    logic [TD_W-1:0] hi;
    logic [TD_W-1:0] lo;
    hi = TD_W'(PRE_HI) * TD_W'(r.no);
    lo = TD_W'(PRE_HI - PRE_LO) * TD_W'(r.a);
    return hi - lo;
  endfunction
endpackage

// File: rtl/pss_serial_load.sv
module pss_serial_load
  import pss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   ser_clk,
  input  logic   ser_dat,
  input  logic   ser_le,
  output logic   load_stb,
  output ratio_t load_val
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, sdat_s, sle_s;
  logic                   sclk_d, sle_d;
  logic [WORD_W-1:0]      shreg;
  logic                   shift_evt, latch_evt;
  ratio_t                 cand;

  assign shift_evt = sclk_s[TOP] & ~sclk_d;
  assign latch_evt = sle_s[TOP] & ~sle_d;
  assign cand      = ratio_t'(shreg);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s   <= '0;
      sdat_s   <= '0;
      sle_s    <= '0;
      sclk_d   <= 1'b0;
      sle_d    <= 1'b0;
      shreg    <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      sclk_s   <= {sclk_s[TOP-1:0], ser_clk};
      sdat_s   <= {sdat_s[TOP-1:0], ser_dat};
      sle_s    <= {sle_s[TOP-1:0], ser_le};
      sclk_d   <= sclk_s[TOP];
      sle_d    <= sle_s[TOP];
      load_stb <= 1'b0;
      if (shift_evt) shreg <= {shreg[WORD_W-2:0], sdat_s[TOP]};
      if (latch_evt && ratio_ok(cand)) begin
        load_stb <= 1'b1;
        load_val <= cand;
      end
    end
  end
endmodule

// File: rtl/pss_ref_div.sv
module pss_ref_div #(
  parameter int DIV = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  output logic ref_tick
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      ref_tick <= 1'b0;
    end else begin
      ref_tick <= 1'b0;
      if (ref_en) begin
        if (cnt_q == CW'(DIV - 1)) begin
          cnt_q    <= '0;
          ref_tick <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pss_fb_div.sv
module pss_fb_div
  import pss_pkg::*;
#(
  parameter int NO_RST = 5,
  parameter int A_RST  = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   vco_en,
  input  logic   load_stb,
  input  ratio_t load_val,
  output logic   fb_tick,
  output logic   mod_ctl,
  output logic   pres_out,
  output logic   fb_boundary,
  output ratio_t act_ratio
);
  logic [PW-1:0]   pres_cnt;
  logic [NO_W-1:0] main_cnt;
  logic [A_W-1:0]  swal_cnt;
  ratio_t          pend_q;
  logic            pend_v;

  assign mod_ctl     = swal_cnt < act_ratio.a;
  assign pres_out    = vco_en &&
                       (pres_cnt == (mod_ctl ? PW'(PRE_LO - 1) : PW'(PRE_HI - 1)));
  assign fb_boundary = pres_out && (main_cnt == act_ratio.no - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_cnt  <= '0;
      main_cnt  <= '0;
      swal_cnt  <= '0;
      act_ratio <= '{no: NO_W'(NO_RST), a: A_W'(A_RST)};
      pend_q    <= '0;
      pend_v    <= 1'b0;
      fb_tick   <= 1'b0;
    end else begin
      fb_tick <= fb_boundary;
      if (vco_en) pres_cnt <= pres_out ? '0 : pres_cnt + 1'b1;
      if (pres_out) begin
        if (fb_boundary) begin
          main_cnt <= '0;
          swal_cnt <= '0;
          if (pend_v) begin
            act_ratio <= pend_q;
            pend_v    <= 1'b0;
          end
        end else begin
          main_cnt <= main_cnt + 1'b1;
          if (mod_ctl) swal_cnt <= swal_cnt + 1'b1;
        end
      end
      if (load_stb) begin
        pend_q <= load_val;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_pfd_lock.sv
module pss_pfd_lock #(
  parameter int WIN      = 2,
  parameter int LOCK_CNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic up,
  output logic dn,
  output logic unlock_n,
  output logic bad_evt
);
  localparam int GAP_W = $clog2(WIN + 2);
  localparam int LC_W  = $clog2(LOCK_CNT + 1);

  logic [GAP_W-1:0] gap_q;
  logic [LC_W-1:0]  lc_q;
  logic             locked_q;
  logic             both, one, good_evt;

  assign both     = up && dn;
  assign one      = up ^ dn;
  assign good_evt = both && (gap_q <= GAP_W'(WIN));
  assign bad_evt  = one && (gap_q == GAP_W'(WIN));
  assign unlock_n = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up       <= 1'b0;
      dn       <= 1'b0;
      gap_q    <= '0;
      lc_q     <= '0;
      locked_q <= 1'b0;
    end else begin
      if (both) begin
        up <= ref_tick;
        dn <= fb_tick;
      end else begin
        up <= up | ref_tick;
        dn <= dn | fb_tick;
      end
      if (one) begin
        if (gap_q != GAP_W'(WIN + 1)) gap_q <= gap_q + 1'b1;
      end else begin
        gap_q <= '0;
      end
      if (bad_evt) begin
        lc_q     <= '0;
        locked_q <= 1'b0;
      end else if (good_evt) begin
        if (lc_q == LC_W'(LOCK_CNT - 1)) locked_q <= 1'b1;
        if (lc_q != LC_W'(LOCK_CNT)) lc_q <= lc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_synth_ctrl.sv
module pss_synth_ctrl
  import pss_pkg::*;
#(
  parameter int REF_DIV      = 18,
  parameter int NO_RST       = 5,
  parameter int A_RST        = 2,
  parameter int LOCK_WIN     = 2,
  parameter int LOCK_PERIODS = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic vco_en,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_le,
  output logic ref_tick,
  output logic fb_tick,
  output logic mod_ctl,
  output logic up,
  output logic dn,
  output logic unlock_n
);
  logic   load_stb;
  ratio_t load_val;
  ratio_t act_ratio;
  logic   pres_out;
  logic   fb_boundary;
  logic   bad_evt;

  pss_serial_load #(.SYNC_STAGES(SYNC_STAGES)) ser_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .load_stb(load_stb), .load_val(load_val)
  );

  pss_ref_div #(.DIV(REF_DIV)) rdiv_i (
    .clk(clk), .rst(rst), .ref_en(ref_en), .ref_tick(ref_tick)
  );

  pss_fb_div #(.NO_RST(NO_RST), .A_RST(A_RST)) fdiv_i (
    .clk(clk), .rst(rst), .vco_en(vco_en), .load_stb(load_stb), .load_val(load_val),
    .fb_tick(fb_tick), .mod_ctl(mod_ctl), .pres_out(pres_out),
    .fb_boundary(fb_boundary), .act_ratio(act_ratio)
  );

  pss_pfd_lock #(.WIN(LOCK_WIN), .LOCK_CNT(LOCK_PERIODS)) pfd_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .up(up), .dn(dn), .unlock_n(unlock_n), .bad_evt(bad_evt)
  );
endmodule

// File: rtl/pss_synth_ctrl_chk.sv
module pss_synth_ctrl_chk
  import pss_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   vco_en,
  input logic   up,
  input logic   dn,
  input logic   unlock_n,
  input logic   mod_ctl,
  input logic   pres_out,
  input logic   fb_boundary,
  input ratio_t act,
  input logic   bad_evt
);
  logic [TD_W-1:0] vcnt_q;

  always_ff @(posedge clk) begin
    if (rst) vcnt_q <= '0;
    else if (fb_boundary) vcnt_q <= '0;
    else if (vco_en) vcnt_q <= vcnt_q + 1'b1;
  end

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!unlock_n && !up && !dn));

  a_r2_period_len: assert property (@(posedge clk) disable iff (rst)
    fb_boundary |-> ((vcnt_q + 1'b1) == total_div(act)));

  a_r3_modulus_steps: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_ctl) |-> $past(pres_out));

  a_r5_ratio_valid: assert property (@(posedge clk) disable iff (rst)
    ratio_ok(act));

  a_r6_ratio_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> $past(fb_boundary));

  a_r7_pfd_clear: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> !(up && dn));

  a_r9_lock_drop: assert property (@(posedge clk) disable iff (rst)
    bad_evt |=> !unlock_n);
endmodule

bind pss_synth_ctrl pss_synth_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .vco_en(vco_en), .up(up), .dn(dn), .unlock_n(unlock_n),
  .mod_ctl(mod_ctl), .pres_out(pres_out), .fb_boundary(fb_boundary),
  .act(act_ratio), .bad_evt(bad_evt)
);

// File: tb/pss_synth_ctrl_tb_top.sv
`timescale 1ns/1ps
module pss_synth_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_en = 1'b0, vco_en = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic ref_tick, fb_tick, mod_ctl, up, dn, unlock_n;

  always #2.5 clk = ~clk;

  pss_synth_ctrl dut_i (
    .clk(clk), .rst(rst), .ref_en(ref_en), .vco_en(vco_en),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_tick(ref_tick), .fb_tick(fb_tick), .mod_ctl(mod_ctl),
    .up(up), .dn(dn), .unlock_n(unlock_n)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int vco_prob = 100, ref_prob = 100, vco_hold = 0;
  int tick_count = 0, pulses_since = 0, sw_pulses = 0;
  int iv_hist [8];
  int sw_hist [8];
  int rtick_count = 0, ref_since = 0, last_ref_iv = 0;
  int updn_diff = 0, up_only = 0;
  int le_tc = 0;
  int exp_n = 18;
  int seed_val;

  function automatic int exp_div(input int no, input int a);
    return no * 4 - a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus driver and period bookkeeping, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      ref_en = 1'b0; vco_en = 1'b0;
      pulses_since = 0; sw_pulses = 0; ref_since = 0;
    end else begin
      if (fb_tick) begin
        tick_count++;
        iv_hist[tick_count % 8] = pulses_since;
        sw_hist[tick_count % 8] = sw_pulses;
        pulses_since = 0; sw_pulses = 0;
      end
      if (ref_tick) begin
        rtick_count++;
        last_ref_iv = ref_since;
        ref_since = 0;
      end
      if (up != dn) updn_diff++;
      if (up && !dn) up_only++;
      if (vco_hold > 0) begin
        vco_hold--;
        vco_en = 1'b0;
      end else begin
        vco_en = ($urandom_range(99) < vco_prob);
      end
      if (vco_en) begin
        pulses_since++;
        if (mod_ctl) sw_pulses++;
      end
      ref_en = ($urandom_range(99) < ref_prob);
      if (ref_en) ref_since++;
    end
  end

  task automatic wait_tick(input int k);
    while (tick_count < k) @(posedge clk);
  endtask

  task automatic pulse_le();
    repeat (3) @(negedge clk);
    ser_le = 1'b1;
    le_tc = tick_count;
    repeat (3) @(negedge clk);
    ser_le = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input int no, input int a, input bit latch);
    logic [19:0] w;
    w = {12'(no), 8'(a)};
    for (int i = 19; i >= 0; i--) begin
      ser_dat = w[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
    if (latch) pulse_le();
  endtask

  // R4 R6 R2 R3: latch a ratio, check the straddling period and a later one
  task automatic load_and_check(input int no, input int a);
    int nn;
    nn = exp_div(no, a);
    send_word(no, a, 1'b1);
    wait_tick(le_tc + 1);
    check(iv_hist[(le_tc + 1) % 8] == exp_n, "R6 old N kept", iv_hist[(le_tc + 1) % 8], exp_n);
    wait_tick(le_tc + 4);
    check(iv_hist[(le_tc + 4) % 8] == nn, "R2 N=4No-A", iv_hist[(le_tc + 4) % 8], nn);
    check(sw_hist[(le_tc + 4) % 8] == 3 * a, "R3 swallow edges", sw_hist[(le_tc + 4) % 8], 3 * a);
    exp_n = nn;
  endtask

  task automatic expect_unchanged(input string req);
    wait_tick(le_tc + 4);
    check(iv_hist[(le_tc + 4) % 8] == exp_n, req, iv_hist[(le_tc + 4) % 8], exp_n);
  endtask

  task automatic lock_run(input int d);
    rst = 1'b1;
    vco_prob = 100; ref_prob = 100;
    repeat (3) @(negedge clk);
    vco_hold = d;
    rst = 1'b0;
    repeat (180) @(negedge clk);
    check(unlock_n == 1'b0, "R8 not yet locked", int'(unlock_n), 0);
    updn_diff = 0; up_only = 0;
    repeat (300) @(negedge clk);
    check(unlock_n == (d <= 2), "R8 lock vs offset", int'(unlock_n), int'(d <= 2));
    if (d == 0) check(updn_diff == 0, "R7 aligned up/dn", updn_diff, 0);
    if (d == 2) check(up_only > 0, "R7 up leads", up_only, 1);
  endtask

  initial begin
    int rc;
    seed_val = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    check(unlock_n == 1'b0, "R10 unlock_n in reset", int'(unlock_n), 0);
    check(up == 1'b0 && dn == 1'b0, "R10 up/dn in reset", int'({up, dn}), 0);
    rst = 1'b0;
    vco_prob = 60; ref_prob = 70;

    wait_tick(3);
    check(iv_hist[3 % 8] == 18, "R10 default ratio", iv_hist[3 % 8], 18);
    check(sw_hist[3 % 8] == 6, "R3 default swallow", sw_hist[3 % 8], 6);
    rc = rtick_count;
    while (rtick_count < rc + 2) @(posedge clk);
    check(last_ref_iv == 18, "R1 ref divide", last_ref_iv, 18);

    load_and_check(1, 0);
    load_and_check(3, 2);
    load_and_check(60, 59);
    for (int k = 0; k < 6; k++) begin
      int a, no;
      a = $urandom_range(40);
      no = a + 1 + $urandom_range(59);
      load_and_check(no, a);
    end

    send_word(7, 7, 1'b1);
    expect_unchanged("R5 No==A rejected");
    send_word(3, 200, 1'b1);
    expect_unchanged("R5 No<A rejected");

    send_word(20, 5, 1'b0);
    le_tc = tick_count;
    expect_unchanged("R4 no effect without latch");
    pulse_le();
    wait_tick(le_tc + 4);
    check(iv_hist[(le_tc + 4) % 8] == 75, "R4 latch alone applies", iv_hist[(le_tc + 4) % 8], 75);
    exp_n = 75;

    vco_prob = 100;
    load_and_check(4095, 255);

    lock_run(3);
    lock_run(2);
    lock_run(0);

    // R9: change N while locked
    send_word(6, 2, 1'b1);
    up_only = 0;
    repeat (400) @(negedge clk);
    check(unlock_n == 1'b0, "R9 lock lost", int'(unlock_n), 0);
    check(up_only > 0, "R7 up on slow feedback", up_only, 1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule